// File: doc/BRIEF.md
# Burst Data Randomizer

A bit-serial scrambler that sits in the transmit chain of a burst modem. It whitens the outgoing stream by adding each data bit, modulo 2, to a key bit drawn from a linear feedback shift register. The key stream comes from one of two built-in generator polynomials, a 15-stage one and a 6-stage one. A run-time select picks between them.

The stream starts over at every burst. A one-cycle start strobe reloads the register from a programmable seed, so the first scrambled bit of every burst sees the same key bit. Upstream logic raises the bypass control while preamble bits go through. Those bits leave unchanged and the key stream does not move. Upstream logic also drops the input valid during gaps in the data. The register advances only on bits that are actually scrambled. Output is registered, one cycle behind the input.

Top module: `burst_scrambler`

## Requirements
- R1: After reset, `out_valid_o` and `out_bit_o` are 0. The register holds all ones in every stage, with the 15-stage polynomial selected.
- R2: `out_valid_o` equals `in_valid_i` delayed by exactly one clock. Each accepted bit produces its output bit one cycle later.
- R3: Stage 1 is the register input. For a scrambled bit, the key bit is stage n XOR stage m. The output is the data bit XOR that key bit. The register then shifts one place toward stage m, and the key bit enters stage 1.
- R4: `poly_sel_i` = 0 selects m = 15, n = 14 (1 + x^14 + x^15). `poly_sel_i` = 1 selects m = 6, n = 5 (1 + x^5 + x^6).
- R5: When `burst_start_i` is high, the register loads the seed. A bit that is valid in the same cycle is scrambled with the key bit computed from the freshly loaded seed.
- R6: Seed bit k loads stage k+1. With the 6-stage polynomial, only `seed_i[5:0]` is used, and the unused stages stay 0.
- R7: If the used seed bits are all zero, every used stage is loaded with 1 instead.
- R8: A cycle with `in_valid_i` = 0 leaves the register unchanged.
- R9: With `bypass_i` high, a valid bit leaves unchanged, and the register holds its state. This is how preamble bits are passed through.
- R10: `poly_sel_i` is sampled only on a `burst_start_i` cycle. Changing it inside a burst has no effect.
- R11: The used stages of the register never become all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_start_i | input | 1 | One-cycle strobe: reload seed and sample polynomial select |
| poly_sel_i | input | 1 | 0 = 15-stage polynomial, 1 = 6-stage polynomial |
| seed_i | input | 15 | Programmable seed; bit k loads stage k+1 |
| bypass_i | input | 1 | Pass bits unscrambled and hold the register |
| in_valid_i | input | 1 | Input bit qualifier |
| in_bit_i | input | 1 | Serial input bit |
| out_valid_o | output | 1 | Output bit qualifier |
| out_bit_o | output | 1 | Serial output bit |

## Verification
The bench targets the seams of a burst. These include a start strobe that arrives together with the first data bit, a preamble in bypass just before the data, and gap cycles mixed into the data. A design that advanced the register during gaps or bypass, or that used the pre-reload state on the start cycle, would scramble every later bit with a shifted key. It also loads seeds whose used bits are zero, which would freeze a faulty design into a constant key. It also loads 6-stage seeds whose upper bits are set, which leak into the feedback if not masked. Running the 6-stage stream past its 63-bit period, and toggling the select mid-burst, expose a wrong tap or a select that is not latched.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int ST_W      = 15;
  localparam int LONG_LEN  = 15;
  localparam int LONG_TAP  = 14;
  localparam int SHORT_LEN = 6;
  localparam int SHORT_TAP = 5;

  typedef logic [ST_W-1:0] state_t;
  typedef enum logic {POLY_LONG = 1'b0, POLY_SHORT = 1'b1} poly_e;

  function automatic int poly_len(poly_e p);
    return (p == POLY_SHORT) ? SHORT_LEN : LONG_LEN;
  endfunction

  function automatic int poly_tap(poly_e p);
    return (p == POLY_SHORT) ? SHORT_TAP : LONG_TAP;
  endfunction

  // stages in use for a polynomial
  function automatic state_t len_mask(poly_e p);
    state_t m;
    m = '0;
    for (int i = 0; i < ST_W; i++) m[i] = (i < poly_len(p));
    return m;
  endfunction

  // key bit: stage n xor stage m (stage k lives in bit k-1)
  function automatic logic key_bit(state_t s, poly_e p);
    return s[poly_tap(p)-1] ^ s[poly_len(p)-1];
  endfunction

  function automatic state_t lfsr_step(state_t s, poly_e p);
    return {s[ST_W-2:0], key_bit(s, p)} & len_mask(p);
  endfunction

  function automatic state_t seed_fix(state_t seed, poly_e p);
    state_t m;
    m = seed & len_mask(p);
    return (m == '0) ? len_mask(p) : m;
  endfunction
endpackage

// File: rtl/scr_seed_sel.sv
module scr_seed_sel
  import scr_pkg::*;
(
  input  state_t seed_i,
  input  poly_e  poly_i,
  output state_t seed_eff_o,
  output logic   seed_zero_o
);
  always_comb begin
    seed_eff_o  = seed_fix(seed_i, poly_i);
    seed_zero_o = ((seed_i & len_mask(poly_i)) == '0);
  end
endmodule

// File: rtl/scr_lfsr.sv
module scr_lfsr
  import scr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  state_t seed_i,
  input  poly_e  poly_load_i,
  input  logic   advance_i,
  output state_t state_o,
  output poly_e  poly_o,
  output logic   key_o
);
  state_t state_q, eff_state, next_state;
  poly_e  poly_q, eff_poly;

  always_comb begin
    eff_poly   = load_i ? poly_load_i : poly_q;
    eff_state  = load_i ? seed_i : state_q;
    key_o      = key_bit(eff_state, eff_poly);
    next_state = advance_i ? lfsr_step(eff_state, eff_poly) : eff_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= len_mask(POLY_LONG);
      poly_q  <= POLY_LONG;
    end else begin
      state_q <= next_state;
      poly_q  <= eff_poly;
    end
  end

  assign state_o = state_q;
  assign poly_o  = poly_q;

  // R8 / R9: no load and no advance -> state frozen
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !advance_i) |=> $stable(state_q));
  // R10: select only changes on a load
  p_poly_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(poly_q));
  // R11: used stages never all zero
  p_never_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q & len_mask(poly_q)) != '0);
  // R6: unused stages stay clear for the short polynomial
  p_short_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_q == POLY_SHORT) |-> (state_q[ST_W-1:SHORT_LEN] == '0));
endmodule

// File: rtl/scr_mix.sv
module scr_mix (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid_i,
  input  logic in_bit_i,
  input  logic key_i,
  input  logic bypass_i,
  output logic out_valid_o,
  output logic out_bit_o
);
  logic mixed;
  assign mixed = bypass_i ? in_bit_i : (in_bit_i ^ key_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_bit_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_bit_o <= mixed;
    end
  end

  // R2: one-cycle valid latency
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  p_novalid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  // R9: bypassed bit passes unchanged
  p_bypass_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && bypass_i) |=> (out_bit_o == $past(in_bit_i)));
endmodule

// File: rtl/burst_scrambler.sv
module burst_scrambler
  import scr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        burst_start_i,
  input  logic        poly_sel_i,
  input  logic [14:0] seed_i,
  input  logic        bypass_i,
  input  logic        in_valid_i,
  input  logic        in_bit_i,
  output logic        out_valid_o,
  output logic        out_bit_o
);
  poly_e  poly_req, poly_cur;
  state_t seed_eff, lfsr_state;
  logic   seed_zero, key, advance;

  assign poly_req = poly_e'(poly_sel_i);
  assign advance  = in_valid_i & ~bypass_i;

  scr_seed_sel u_seed (
    .seed_i      (state_t'(seed_i)),
    .poly_i      (poly_req),
    .seed_eff_o  (seed_eff),
    .seed_zero_o (seed_zero)
  );

  scr_lfsr u_lfsr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (burst_start_i),
    .seed_i      (seed_eff),
    .poly_load_i (poly_req),
    .advance_i   (advance),
    .state_o     (lfsr_state),
    .poly_o      (poly_cur),
    .key_o       (key)
  );

  scr_mix u_mix (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_bit_i    (in_bit_i),
    .key_i       (key),
    .bypass_i    (bypass_i),
    .out_valid_o (out_valid_o),
    .out_bit_o   (out_bit_o)
  );

  // R5: start without an advancing bit leaves exactly the seed
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start_i && !advance) |=> (lfsr_state == $past(seed_eff)));
  // R7: zero seed becomes all ones in the used stages
  p_zero_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start_i && !advance && seed_zero) |=> (lfsr_state == len_mask(poly_cur)));
  // R4 / R10: load takes the requested polynomial
  p_poly_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start_i |=> (poly_cur == $past(poly_req)));
endmodule

// File: tb/tb_burst_scrambler.sv
module tb_burst_scrambler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_start = 1'b0, poly_sel = 1'b0, bypass = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic [14:0] seed = '0;
  logic out_valid, out_bit;

  int checks = 0, failures = 0;
  logic  exp_q[$];
  string tag_q[$];

  // independent model: stages 1..15
  logic mdl[1:15];
  logic m_short;

  always #2.5 clk = ~clk;

  burst_scrambler dut (
    .clk(clk), .rst_n(rst_n), .burst_start_i(burst_start), .poly_sel_i(poly_sel),
    .seed_i(seed), .bypass_i(bypass), .in_valid_i(in_valid), .in_bit_i(in_bit),
    .out_valid_o(out_valid), .out_bit_o(out_bit));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic d, input logic byp,
                       input logic st, input logic ps, input logic [14:0] sd,
                       input string tag);
    int len, tap;
    logic kb, any;
    @(negedge clk);
    in_valid = v; in_bit = d; bypass = byp; burst_start = st;
    poly_sel = ps; seed = sd;
    if (st) begin
      m_short = ps;
      len = m_short ? 6 : 15;
      any = 1'b0;
      for (int k = 1; k <= 15; k++) begin
        mdl[k] = (k <= len) ? sd[k-1] : 1'b0;
        any |= mdl[k];
      end
      if (!any) for (int k = 1; k <= len; k++) mdl[k] = 1'b1;
    end
    len = m_short ? 6 : 15;
    tap = m_short ? 5 : 14;
    if (v) begin
      if (byp) exp_q.push_back(d);
      else begin
        kb = mdl[tap] ^ mdl[len];
        exp_q.push_back(d ^ kb);
        for (int k = 15; k >= 2; k--) mdl[k] = mdl[k-1];
        mdl[1] = kb;
        for (int k = len + 1; k <= 15; k++) mdl[k] = 1'b0;
      end
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, poly_sel, seed, "idle");
  endtask

  function automatic logic pat(input int i, input int k);
    return ((i * 7 + k) % 5) < 2;
  endfunction

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 actual=unexpected_valid expected=no_output");
      end else begin
        logic e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_bit, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 1; k <= 15; k++) mdl[k] = 1'b1;
    m_short = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid", out_valid, 1'b0);
    check("R1 out_bit", out_bit, 1'b0);
    rst_n = 1'b1;
    // R1: reset state drives stream without a start
    for (int i = 0; i < 20; i++) drive(1'b1, pat(i, 1), 1'b0, 1'b0, 1'b0, '0, "R1");
    idle(2);
    // R3 R4 R5: long polynomial burst, start with first bit
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 15'h1234, "R5");
    for (int i = 0; i < 40; i++) drive(1'b1, pat(i, 3), 1'b0, 1'b0, 1'b0, 15'h1234, "R3");
    // R8: gaps mixed in
    for (int i = 0; i < 40; i++) drive(pat(i, 2), pat(i, 4), 1'b0, 1'b0, 1'b0, 15'h1234, "R8");
    // R9: preamble in bypass, then data, after a start without data
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 15'h5A5A, "R5");
    for (int i = 0; i < 12; i++) drive(1'b1, pat(i, 0), 1'b1, 1'b0, 1'b0, 15'h5A5A, "R9");
    for (int i = 0; i < 30; i++) drive(1'b1, pat(i, 1), 1'b0, 1'b0, 1'b0, 15'h5A5A, "R9");
    // R5 R9: start together with a bypassed bit
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 15'h0F0F, "R9");
    for (int i = 0; i < 20; i++) drive(1'b1, pat(i, 2), 1'b0, 1'b0, 1'b0, 15'h0F0F, "R5");
    // R6 R4: short polynomial, upper seed bits set, beyond the 63-bit period
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 15'h7FC5, "R6");
    for (int i = 0; i < 140; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 15'h7FC5, "R4");
    // R7 R11: zero seeds for both polynomials
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, "R7");
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0000, "R11");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 15'h7FC0, "R7");
    for (int i = 0; i < 70; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 15'h7FC0, "R11");
    // R10: select toggles inside a burst
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 15'h002B, "R10");
    for (int i = 0; i < 30; i++) drive(1'b1, pat(i, 3), 1'b0, 1'b0, i[0], 15'h002B, "R10");
    // R5: mid-burst restart reproduces the key
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 15'h1234, "R5");
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 15'h1234, "R5");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule